// File: doc/BRIEF.md
# Single-Precision Sign-Injection and Register-Move Unit

This unit sits on the single-precision data path between a narrow integer register file, a wider floating-point register file and the load/store pipe. Per request it does one of three sign-injection operations, a raw bit move in either direction between the two register files, NaN-boxing of a loaded word, or qualification of a floating-point store against the floating-point context enable.

Every single-precision value written toward the wider floating-point file has its upper bits filled with ones. Sign-injection inputs must carry that box. An input without it is treated as the canonical quiet NaN. Stores are dropped completely while the floating-point context is off. All results are registered, one cycle after the request, and the operation itself raises no exception flags.

Top module: `fp_sgnmove`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every output is zero: results, data, valid flags and the store enable.
- R2: `op_sel`=0 (copy-sign) gives result bits 30:0 from operand A, with bit 31 equal to bit 31 of operand B.
- R3: `op_sel`=1 (negated copy-sign) gives bits 30:0 from A, with bit 31 equal to the inverse of B's bit 31.
- R4: `op_sel`=2 (xor-sign) gives bits 30:0 from A, with bit 31 equal to the XOR of the bit 31 values of A and B.
- R5: In sign injection, an operand whose bits FLEN-1:32 are not all ones is first replaced by 0x7FC00000. This applies to either operand, and to the sign source as well as to the magnitude source.
- R6: Every valid floating-point result (`f_valid`=1) has bits FLEN-1:32 all ones.
- R7: `op_sel`=3 (integer to FP move) puts `xa[31:0]` unchanged in the low 32 bits of `f_result`.
- R8: `op_sel`=4 (FP to integer move) puts `fa[31:0]` in `x_result`, sign-extended from bit 31 to XLEN bits, and asserts `x_valid`.
- R9: `op_sel`=5 (load) puts `ld_data` in the low 32 bits of `f_result`, with the upper bits boxed.
- R10: `op_sel`=6 (store) with `fs_state` nonzero raises `st_en` for exactly one cycle, with `st_data` = `fa[31:0]`. With `fs_state`=0 the store raises no `st_en` and `st_data` stays 0.
- R11: Results appear in the cycle after the accepted request, and at most one of `f_valid`, `x_valid` and `st_en` is high. Without `op_valid`, or with `op_sel`=7, all three stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code (0..6, 7 reserved) |
| fa | input | FLEN | FP operand A, and the store source |
| fb | input | FLEN | FP operand B (sign source) |
| xa | input | XLEN | Integer operand |
| ld_data | input | 32 | Word returned by a load |
| fs_state | input | 2 | FP context state field |
| f_result | output | FLEN | Boxed FP result |
| f_valid | output | 1 | FP result valid |
| x_result | output | XLEN | Integer result |
| x_valid | output | 1 | Integer result valid |
| st_en | output | 1 | Store enable pulse |
| st_data | output | 32 | Store data |

## Verification
The bench builds the unit with FLEN=64 and XLEN=64. With those values the sign extension of the FP-to-integer move covers 32 real upper bits, and the box check has a full 32-bit upper field in which a single cleared bit must be caught. The bench sweeps every combination of operation, operand sign and box validity over several magnitude patterns. Expected values come from bit arithmetic in the bench. It also drives the store with each `fs_state` value and drives the reserved code.

// File: rtl/fpmv_pkg.sv
package fpmv_pkg;
  localparam int SW = 32;
  localparam logic [SW-1:0] QNAN_CANON = 32'h7FC0_0000;

  typedef enum logic [2:0] {
    OP_CPSGN  = 3'd0,
    OP_NEGSGN = 3'd1,
    OP_XORSGN = 3'd2,
    OP_I2F    = 3'd3,
    OP_F2I    = 3'd4,
    OP_LOAD   = 3'd5,
    OP_STORE  = 3'd6,
    OP_NONE   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SG_COPY = 2'd0,
    SG_NEG  = 2'd1,
    SG_XOR  = 2'd2
  } sgn_mode_e;
endpackage

// File: rtl/fpmv_unbox.sv
module fpmv_unbox
  import fpmv_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [FLEN-1:0] wide_i,
  output logic [SW-1:0]   narrow_o
);
  generate
    if (FLEN > SW) begin : g_check
      localparam int HI = FLEN - SW;
      logic boxed;
      assign boxed    = &wide_i[FLEN-1:SW];
      assign narrow_o = boxed ? wide_i[SW-1:0] : QNAN_CANON;
      logic unused_hi;
      assign unused_hi = ^HI;
    end else begin : g_pass
      assign narrow_o = wide_i[SW-1:0];
    end
  endgenerate
endmodule

// File: rtl/fpmv_box.sv
module fpmv_box
  import fpmv_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [SW-1:0]   narrow_i,
  output logic [FLEN-1:0] wide_o
);
  generate
    if (FLEN > SW) begin : g_fill
      assign wide_o = {{(FLEN-SW){1'b1}}, narrow_i};
    end else begin : g_pass
      assign wide_o = narrow_i[FLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/fpmv_sgnj.sv
module fpmv_sgnj
  import fpmv_pkg::*;
(
  input  sgn_mode_e     mode_i,
  input  logic [SW-1:0] mag_i,
  input  logic [SW-1:0] sgn_i,
  output logic [SW-1:0] res_o
);
  logic new_sign;
  always_comb begin
    unique case (mode_i)
      SG_COPY: new_sign = sgn_i[SW-1];
      SG_NEG:  new_sign = ~sgn_i[SW-1];
      SG_XOR:  new_sign = sgn_i[SW-1] ^ mag_i[SW-1];
      default: new_sign = sgn_i[SW-1];
    endcase
  end
  assign res_o = {new_sign, mag_i[SW-2:0]};
endmodule

// File: rtl/fp_sgnmove.sv
module fp_sgnmove
  import fpmv_pkg::*;
#(
  parameter int FLEN = 64,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [2:0]      op_sel,
  input  logic [FLEN-1:0] fa,
  input  logic [FLEN-1:0] fb,
  input  logic [XLEN-1:0] xa,
  input  logic [SW-1:0]   ld_data,
  input  logic [1:0]      fs_state,
  output logic [FLEN-1:0] f_result,
  output logic            f_valid,
  output logic [XLEN-1:0] x_result,
  output logic            x_valid,
  output logic            st_en,
  output logic [SW-1:0]   st_data
);
  op_e       op;
  sgn_mode_e smode;
  logic [SW-1:0]   a_n, b_n, sgnj_res, f_narrow;
  logic [FLEN-1:0] f_wide;
  logic [XLEN-1:0] x_ext;
  logic            is_sgnj, is_fwr, is_xwr, is_st;

  assign op    = op_e'(op_sel);
  assign smode = sgn_mode_e'(op_sel[1:0]);

  fpmv_unbox #(.FLEN(FLEN)) u_unbox_a (.wide_i(fa), .narrow_o(a_n));
  fpmv_unbox #(.FLEN(FLEN)) u_unbox_b (.wide_i(fb), .narrow_o(b_n));
  fpmv_sgnj u_sgnj (.mode_i(smode), .mag_i(a_n), .sgn_i(b_n), .res_o(sgnj_res));

  always_comb begin
    is_sgnj  = (op == OP_CPSGN) || (op == OP_NEGSGN) || (op == OP_XORSGN);
    is_fwr   = op_valid && (is_sgnj || op == OP_I2F || op == OP_LOAD);
    is_xwr   = op_valid && (op == OP_F2I);
    is_st    = op_valid && (op == OP_STORE) && (fs_state != 2'd0);
    f_narrow = sgnj_res;
    if (op == OP_I2F)  f_narrow = xa[SW-1:0];
    if (op == OP_LOAD) f_narrow = ld_data;
  end

  fpmv_box #(.FLEN(FLEN)) u_box (.narrow_i(f_narrow), .wide_o(f_wide));

  generate
    if (XLEN > SW) begin : g_sext
      assign x_ext = {{(XLEN-SW){fa[SW-1]}}, fa[SW-1:0]};
    end else begin : g_trunc
      assign x_ext = fa[XLEN-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      f_result <= '0;
      f_valid  <= 1'b0;
      x_result <= '0;
      x_valid  <= 1'b0;
      st_en    <= 1'b0;
      st_data  <= '0;
    end else begin
      f_valid <= is_fwr;
      x_valid <= is_xwr;
      st_en   <= is_st;
      if (is_fwr) f_result <= f_wide;
      if (is_xwr) x_result <= x_ext;
      st_data <= is_st ? fa[SW-1:0] : '0;
    end
  end

  AST_ONE_SINK: assert property (@(posedge clk) disable iff (rst)
    $onehot0({f_valid, x_valid, st_en})); // R11
  AST_ST_CAUSE: assert property (@(posedge clk) disable iff (rst)
    st_en |-> ($past(op_valid) && $past(op_sel) == 3'd6 && $past(fs_state) != 2'd0)); // R10
  AST_ST_OFF: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd6 && fs_state == 2'd0) |=> (!st_en && st_data == '0)); // R10
  AST_ST_DATA: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd6 && fs_state != 2'd0) |=> (st_data == $past(fa[SW-1:0]))); // R10
  AST_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_sel == 3'd7) |=> !(f_valid || x_valid || st_en)); // R11

  generate
    if (FLEN > SW) begin : g_fchk
      AST_FBOX: assert property (@(posedge clk) disable iff (rst)
        f_valid |-> (&f_result[FLEN-1:SW])); // R6
      AST_MAG_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel <= 3'd2 && (&fa[FLEN-1:SW]))
          |=> (f_result[SW-2:0] == $past(fa[SW-2:0]))); // R2
    end
    if (XLEN > SW) begin : g_xchk
      AST_SEXT: assert property (@(posedge clk) disable iff (rst)
        x_valid |-> (x_result[XLEN-1:SW] == {(XLEN-SW){x_result[SW-1]}})); // R8
    end
  endgenerate
endmodule

// File: tb/fp_sgnmove_tb.sv
module fp_sgnmove_tb_top;
  localparam int FL = 64;
  localparam int XL = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic          op_valid;
  logic [2:0]    op_sel;
  logic [FL-1:0] fa, fb;
  logic [XL-1:0] xa;
  logic [31:0]   ld_data;
  logic [1:0]    fs_state;
  logic [FL-1:0] f_result;
  logic          f_valid;
  logic [XL-1:0] x_result;
  logic          x_valid;
  logic          st_en;
  logic [31:0]   st_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fp_sgnmove #(.FLEN(FL), .XLEN(XL)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .fa(fa), .fb(fb), .xa(xa), .ld_data(ld_data), .fs_state(fs_state),
    .f_result(f_result), .f_valid(f_valid), .x_result(x_result),
    .x_valid(x_valid), .st_en(st_en), .st_data(st_data));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] unbox(input logic [FL-1:0] v);
    return (v[FL-1:32] == '1) ? v[31:0] : 32'h7FC0_0000;
  endfunction

  // Drive one request at a falling edge; the next falling edge follows the capturing rising edge.
  task automatic issue(input logic [2:0] op, input logic [FL-1:0] a, input logic [FL-1:0] b,
                       input logic [XL-1:0] x, input logic [31:0] ld, input logic [1:0] fs);
    op_valid = 1'b1; op_sel = op; fa = a; fb = b; xa = x; ld_data = ld; fs_state = fs;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] mags [3];
    mags[0] = 32'h3F80_0000; mags[1] = 32'h7F80_0001; mags[2] = 32'h0000_0000;
    rst = 1'b1; op_valid = 1'b0; op_sel = '0; fa = '0; fb = '0; xa = '0; ld_data = '0; fs_state = '0;
    @(negedge clk); @(negedge clk);
    chk("R1 reset f", {63'd0, f_valid, f_result}, '0);
    chk("R1 reset x/st", {x_valid, st_en, st_data, x_result}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {f_valid, x_valid, st_en, st_data}, '0);

    // Sign-injection sweep: operation x signs x box validity x magnitude pattern.
    for (int op = 0; op < 3; op++)
      for (int m = 0; m < 3; m++)
        for (int s = 0; s < 16; s++) begin
          logic [FL-1:0] a, b;
          logic [31:0] an, bn, e;
          logic sgn;
          a = {(s[2] ? 32'hFFFF_FFFF : 32'hFFFF_FFFE), s[0], mags[m][30:0]};
          b = {(s[3] ? 32'hFFFF_FFFF : 32'h7FFF_FFFF), s[1], ~mags[m][30:0]};
          an = unbox(a); bn = unbox(b);
          sgn = (op == 0) ? bn[31] : (op == 1) ? ~bn[31] : (an[31] ^ bn[31]);
          e = {sgn, an[30:0]};
          issue(3'(op), a, b, '0, '0, 2'd1);
          case (op)
            0: chk("R2 copy-sign", {f_valid, f_result}, {1'b1, 32'hFFFF_FFFF, e});
            1: chk("R3 neg-sign", {f_valid, f_result}, {1'b1, 32'hFFFF_FFFF, e});
            default: chk("R4 xor-sign", {f_valid, f_result}, {1'b1, 32'hFFFF_FFFF, e});
          endcase
          if (!s[2] || !s[3]) chk("R5 unboxed canon", f_result[31:0], e);
          chk("R6 box", f_result[FL-1:32], 32'hFFFF_FFFF);
        end

    // Integer to FP move.
    for (int k = 0; k < 4; k++) begin
      logic [XL-1:0] x;
      x = {32'hDEAD_0000 + 32'(k), 32'h8000_0001 ^ (32'h1357_9BDF << k)};
      issue(3'd3, '0, '0, x, '0, 2'd1);
      chk("R7 int-to-fp", {f_valid, f_result}, {1'b1, 32'hFFFF_FFFF, x[31:0]});
    end

    // FP to integer move, both sign polarities.
    for (int k = 0; k < 4; k++) begin
      logic [FL-1:0] a;
      logic [31:0] lo;
      lo = (k[0] ? 32'h8000_0000 : 32'h0) | (32'h0123_4567 << k);
      a = {32'h5555_5555, lo};
      issue(3'd4, a, '0, '0, '0, 2'd1);
      chk("R8 fp-to-int", {x_valid, f_valid, x_result},
          {1'b1, 1'b0, {32{lo[31]}}, lo});
    end

    // Load boxing.
    for (int k = 0; k < 3; k++) begin
      logic [31:0] w;
      w = 32'hFFFF_0000 >> (8 * k);
      issue(3'd5, '0, '0, '0, w, 2'd0);
      chk("R9 load box", {f_valid, f_result}, {1'b1, 32'hFFFF_FFFF, w});
    end

    // Stores under each context state.
    for (int fs = 0; fs < 4; fs++) begin
      logic [FL-1:0] a;
      a = {32'h0, 32'hCAFE_0000 | 32'(fs)};
      issue(3'd6, a, '0, '0, '0, 2'(fs));
      if (fs == 0) chk("R10 store off", {st_en, st_data}, '0);
      else chk("R10 store on", {st_en, st_data}, {1'b1, a[31:0]});
      chk("R11 store only", {f_valid, x_valid}, '0);
      @(negedge clk);
      chk("R10 single pulse", {st_en, st_data}, '0);
    end

    // Reserved code and idle.
    issue(3'd7, '1, '1, '1, '1, 2'd3);
    chk("R11 reserved", {f_valid, x_valid, st_en}, '0);
    op_sel = 3'd6; fs_state = 2'd3;
    @(negedge clk);
    chk("R11 no strobe", {f_valid, x_valid, st_en}, '0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule